// File: doc/BRIEF.md
# Register Rename Map with Free List

This block is the renaming step of an out-of-order pipeline front end. Programs name a small set of architectural registers. The block maps each of those names onto one tag drawn from a larger pool of physical registers. For every instruction presented, it looks up the two source names and returns the physical tags they currently stand for. If the instruction writes a register, the block takes a fresh tag from its free list and points the destination name at that tag. It also reports the tag the name held before, so that tag can be released once the overwriting instruction retires.

Every write gets its own physical register. Because of this, a later instruction sequence that reuses a register name is independent of an earlier sequence that used the same name. The later sequence does not wait for the earlier one, even if the earlier one is stalled.

The retire logic returns tags through a separate free port. Returned tags join the back of the free list. When no tag is left and the instruction writes a register, the block lowers its ready output and holds that instruction.

Top module: `renameMap`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The free list holds tags ARCH_REGS to PHYS_REGS-1 in ascending order, with ARCH_REGS at the front (with the defaults, tags 8 to 31).
- R2: An accepted write (inValid, dstWrite and renReady all high at a clock edge) is given the tag at the front of the free list, presented on physDst. That tag differs from every tag mapped at that moment.
- R3: physSrcA and physSrcB show, in the same cycle, the tag of the most recent accepted write to srcA and srcB. An instruction whose source equals its own destination still reads the mapping from before its own write. The new mapping is visible from the next cycle onward.
- R4: physOld shows the tag that dstArch maps to before the current instruction's write.
- R5: An instruction with dstWrite low takes no tag and leaves the map unchanged. renReady stays high for it even when the free list is empty.
- R6: When the free list is empty and dstWrite is high, renReady is low. A presented write is then not accepted: the map is unchanged and no tag is taken.
- R7: A tag returned with freeValid at a clock edge is appended to the back of the free list. It can be allocated from the next cycle onward, so renReady rises one cycle after a free into an empty list.
- R8: Back-to-back writes to the same architectural name are accepted on consecutive cycles without any tag being freed. Each write gets a new tag, as long as tags remain on the free list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An instruction is presented this cycle |
| dstWrite | input | 1 | The instruction writes a destination register |
| dstArch | input | 3 | Destination architectural name |
| srcA | input | 3 | First source architectural name |
| srcB | input | 3 | Second source architectural name |
| freeValid | input | 1 | A physical tag is returned this cycle |
| freeTag | input | 5 | Returned physical tag |
| renReady | output | 1 | The presented instruction can be accepted this cycle |
| physSrcA | output | 5 | Current tag for srcA |
| physSrcB | output | 5 | Current tag for srcB |
| physDst | output | 5 | Tag allocated to the destination |
| physOld | output | 5 | Previous tag of the destination name |

## Verification
A corrupted map entry shows up on physSrcA or physSrcB the first time that name is read. It also shows up on physOld the next time the name is written. Either way it appears in the same cycle as the lookup, not at the cycle the entry went wrong. A wrong free-list pointer or count shows up differently: a repeated or out-of-order tag appears on physDst at the next allocation, or renReady drops or rises one allocation early or late when the list runs dry. The bench therefore reads every name back after the writes and drains the list completely.

// File: rtl/renamePkg.sv
package renamePkg;
  typedef struct packed {
    logic doAlloc;
    logic doFree;
  } renameStrobes_t;
endpackage

// File: rtl/renameCtrl.sv
module renameCtrl
  import renamePkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           dstWrite,
  input  logic           freeValid,
  input  logic           listEmpty,
  output logic           renReady,
  output renameStrobes_t strobes
);
  always_comb begin
    renReady        = !(dstWrite && listEmpty);
    strobes.doAlloc = inValid && dstWrite && renReady;
    strobes.doFree  = freeValid;
  end

  // R5
  no_write_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !dstWrite) |-> (!strobes.doAlloc && renReady));
endmodule

// File: rtl/renameDatapath.sv
module renameDatapath
  import renamePkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 32,
  localparam int ArchW  = $clog2(ARCH_REGS),
  localparam int PhysW  = $clog2(PHYS_REGS),
  localparam int CountW = $clog2(PHYS_REGS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  renameStrobes_t   strobes,
  input  logic [ArchW-1:0] dstArch,
  input  logic [ArchW-1:0] srcA,
  input  logic [ArchW-1:0] srcB,
  input  logic [PhysW-1:0] freeTag,
  output logic             listEmpty,
  output logic [PhysW-1:0] physSrcA,
  output logic [PhysW-1:0] physSrcB,
  output logic [PhysW-1:0] physDst,
  output logic [PhysW-1:0] physOld
);
  localparam int InitFree = PHYS_REGS - ARCH_REGS;

  logic [ARCH_REGS-1:0][PhysW-1:0] mapTable;
  logic [PhysW-1:0]  freeMem [PHYS_REGS];
  logic [PhysW-1:0]  headPtr, tailPtr;
  logic [CountW-1:0] freeCount;

  function automatic logic [PhysW-1:0] nextPtr(input logic [PhysW-1:0] p);
    return (int'(p) == PHYS_REGS - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    physSrcA  = mapTable[srcA];
    physSrcB  = mapTable[srcB];
    physOld   = mapTable[dstArch];
    physDst   = freeMem[headPtr];
    listEmpty = (freeCount == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ARCH_REGS; i++) mapTable[i] <= PhysW'(i);
    end else if (strobes.doAlloc) begin
      mapTable[dstArch] <= freeMem[headPtr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int j = 0; j < PHYS_REGS; j++)
        freeMem[j] <= (j < InitFree) ? PhysW'(j + ARCH_REGS) : '0;
      headPtr   <= '0;
      tailPtr   <= PhysW'(InitFree);
      freeCount <= CountW'(InitFree);
    end else begin
      if (strobes.doFree) begin
        freeMem[tailPtr] <= freeTag;
        tailPtr          <= nextPtr(tailPtr);
      end
      if (strobes.doAlloc) headPtr <= nextPtr(headPtr);
      case ({strobes.doAlloc, strobes.doFree})
        2'b10:   freeCount <= freeCount - 1'b1;
        2'b01:   freeCount <= freeCount + 1'b1;
        default: freeCount <= freeCount;
      endcase
    end
  end

  // R2
  alloc_fresh_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doAlloc |-> (physDst != physOld));

  // R3
  map_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doAlloc |=> (mapTable[$past(dstArch)] == $past(physDst)));

  // R5
  map_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doAlloc |=> $stable(mapTable));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doAlloc |-> (freeCount != '0));

  // R7
  free_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doFree && !strobes.doAlloc) |=> (freeCount == $past(freeCount) + 1'b1));
endmodule

// File: rtl/renameMap.sv
module renameMap
  import renamePkg::*;
#(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 32,
  localparam int ArchW = $clog2(ARCH_REGS),
  localparam int PhysW = $clog2(PHYS_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             dstWrite,
  input  logic [ArchW-1:0] dstArch,
  input  logic [ArchW-1:0] srcA,
  input  logic [ArchW-1:0] srcB,
  input  logic             freeValid,
  input  logic [PhysW-1:0] freeTag,
  output logic             renReady,
  output logic [PhysW-1:0] physSrcA,
  output logic [PhysW-1:0] physSrcB,
  output logic [PhysW-1:0] physDst,
  output logic [PhysW-1:0] physOld
);
  renameStrobes_t strobes;
  logic           listEmpty;

  renameCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dstWrite(dstWrite),
    .freeValid(freeValid), .listEmpty(listEmpty),
    .renReady(renReady), .strobes(strobes)
  );

  renameDatapath #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dstArch(dstArch),
    .srcA(srcA), .srcB(srcB), .freeTag(freeTag), .listEmpty(listEmpty),
    .physSrcA(physSrcA), .physSrcB(physSrcB), .physDst(physDst), .physOld(physOld)
  );
endmodule

// File: tb/test_renameMap.sv
`timescale 1ns/1ps
module test_renameMap;
  logic clk = 0, rstN = 0, inValid = 0, dstWrite = 0, freeValid = 0;
  logic [2:0] dstArch = 0, srcA = 0, srcB = 0;
  logic [4:0] freeTag = 0;
  logic renReady;
  logic [4:0] physSrcA, physSrcB, physDst, physOld;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  renameMap i_renameMap (.*);

  typedef struct packed {
    logic wr; logic [2:0] dst, a, b; logic [4:0] expA, expB, expDst, expOld;
  } vec_t;

  localparam vec_t Vecs [6] = '{
    '{1'b1, 3'd1, 3'd1, 3'd2, 5'd1,  5'd2,  5'd8,  5'd1},
    '{1'b1, 3'd1, 3'd1, 3'd3, 5'd8,  5'd3,  5'd9,  5'd8},
    '{1'b0, 3'd0, 3'd1, 3'd0, 5'd9,  5'd0,  5'd0,  5'd0},
    '{1'b1, 3'd5, 3'd5, 3'd1, 5'd5,  5'd9,  5'd10, 5'd5},
    '{1'b1, 3'd0, 3'd7, 3'd5, 5'd7,  5'd10, 5'd11, 5'd0},
    '{1'b0, 3'd0, 3'd0, 3'd5, 5'd11, 5'd10, 5'd0,  5'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int allocs;
    logic [4:0] held;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    // R1: identity map after reset
    for (int i = 0; i < 8; i++) begin
      srcA = 3'(i); #1;
      check("R1 identity", physSrcA, i);
    end
    dstWrite = 1; dstArch = 0; #1;
    check("R1 first free tag", physDst, 8);
    dstWrite = 0;
    // table walk: R2 R3 R4 R5
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      inValid = 1; dstWrite = Vecs[k].wr; dstArch = Vecs[k].dst;
      srcA = Vecs[k].a; srcB = Vecs[k].b; #1;
      check("R3 srcA", physSrcA, Vecs[k].expA);
      check("R3 srcB", physSrcB, Vecs[k].expB);
      check("R5 ready", renReady, 1);
      if (Vecs[k].wr) begin
        check("R2 dst tag", physDst, Vecs[k].expDst);
        check("R4 old tag", physOld, Vecs[k].expOld);
      end
    end
    // R8: back-to-back writes to r2 until the list runs dry
    allocs = 0;
    @(negedge clk);
    inValid = 1; dstWrite = 1; dstArch = 2; srcA = 2; #1;
    while (renReady && allocs < 40) begin
      check("R8 fresh tag", physDst, 12 + allocs);
      @(negedge clk); #1;
      allocs++;
    end
    check("R8 alloc count", allocs, 20);
    // R6: stalled write leaves the map alone
    held = physSrcA;
    check("R6 ready low", renReady, 0);
    check("R6 map tag", held, 31);
    @(negedge clk); #1;
    check("R6 map held", physSrcA, held);
    check("R6 still stalled", renReady, 0);
    // R5: non-writing instruction proceeds while empty
    dstWrite = 0; #1;
    check("R5 ready when empty", renReady, 1);
    dstWrite = 1;
    // R7: free tag 1, ready next cycle, then allocated
    @(negedge clk);
    inValid = 0; freeValid = 1; freeTag = 1; #1;
    check("R7 not yet ready", renReady, 0);
    @(negedge clk);
    freeValid = 0; #1;
    check("R7 ready after free", renReady, 1);
    check("R7 freed tag reused", physDst, 1);
    check("R4 old before realloc", physOld, 31);
    inValid = 1;
    @(negedge clk);
    inValid = 0; #1;
    check("R3 new mapping", physSrcA, 1);
    check("R6 empty again", renReady, 0);
    // reset restores identity
    rstN = 0;
    @(negedge clk);
    rstN = 1; #1;
    check("R1 reset remap", physSrcA, 2);
    check("R1 reset ready", renReady, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule